// File: doc/BRIEF.md
# Quarter-wave sine carrier generator

This block produces a digital sine carrier. The carrier multiplies the incoming data samples in a modulator. A 16-bit phase accumulator advances by a programmable frequency increment on each cycle where the step input is high. The sample for the new phase is read from a lookup table that holds only one quarter of a sine period, as unsigned magnitudes.

The two top phase bits select the quadrant. The quadrant decides two things: whether the table is read forward or backward (mirrored), and whether the magnitude is negated. In this way the full period is rebuilt from a quarter of the storage. The table is computed at elaboration time and is not loaded at run time.

Each stepped phase yields one signed sample, registered one cycle after the phase update. A valid flag marks that sample. While step stays low, the phase, the sample and the flag do not advance.

Top module: `carrier_sine_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, before any step, sample is 0 and sample_valid is 0; the internal phase starts at 0.
- R2: Each cycle with step high adds freq_inc to the phase modulo 2^16. With step low the phase keeps its value, and freq_inc has no effect on any later sample.
- R3: A step accepted at clock edge k raises sample_valid for exactly the cycle after edge k+1. Without a step at edge k, sample_valid is low after edge k+1.
- R4: Quadrant 0 (phase bits [15:14] = 00): sample = +M[i], where i = phase bits [13:8].
- R5: Quadrant 1 (phase bits [15:14] = 01): sample = +M[63 - i], so the table is read backward.
- R6: Quadrant 2 (phase bits [15:14] = 10): sample = -M[i] in two's complement.
- R7: Quadrant 3 (phase bits [15:14] = 11): sample = -M[63 - i].
- R8: The table has 64 entries: M[i] = round(127 * sin((2i+1)*pi/256)). This gives a peak of 127 (M[63]) and a smallest value of 2 (M[0]).
- R9: While sample_valid is low, sample holds the last valid value.
- R10: sample never takes the code -128; every valid sample lies in [-127, 127] and is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Advance the phase by freq_inc this cycle |
| freq_inc | input | 16 | Phase increment per step (carrier frequency) |
| sample | output | 8 | Signed carrier sample, two's complement |
| sample_valid | output | 1 | High for one cycle per new sample |

## Verification
A wrong phase value shows as a wrong sample two edges after the step that produced it. Once the phase is off, every later sample stays off, so a single slip in the accumulator is caught at the first sample that follows it. A wrong mirror or sign decision only shows in the quadrant it affects, and it appears as a sample with the wrong index or the wrong sign. For this reason the stimulus drives phases through all four quadrants, through their boundaries and through the 16-bit wrap. A wrong table entry appears as soon as the phase lands on that index, so a unit-step sweep reads every entry in every quadrant.

// File: rtl/sinegen_pkg.sv
package sinegen_pkg;

    // Rounded magnitude of one quarter-table entry, sampled at bin centres
    function automatic int quarter_mag(input int idx, input int depth, input int peak);
        real ang;
        ang = (2.0 * real'(idx) + 1.0) * 3.14159265358979 / (4.0 * real'(depth));
        return $rtoi(real'(peak) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/quarter_rom.sv
module quarter_rom #(
    parameter int IDX_W = 6,
    parameter int MAG_W = 8,
    parameter int PEAK  = 127
) (
    input  logic [IDX_W-1:0] idx,
    output logic [MAG_W-1:0] mag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [MAG_W-1:0] tbl [DEPTH];

    // Entries are constants computed during elaboration
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int VAL = sinegen_pkg::quarter_mag(g, DEPTH, PEAK);
        assign tbl[g] = MAG_W'(VAL);
    end

    assign mag = tbl[idx];
endmodule

// File: rtl/quadrant_fold.sv
module quadrant_fold #(
    parameter int IDX_W = 6
) (
    input  logic [1:0]       quad,
    input  logic [IDX_W-1:0] raw_idx,
    output logic [IDX_W-1:0] rom_idx,
    output logic             negate
);
    // Odd quadrants read the table backward: (DEPTH-1-i) equals bitwise inverse
    assign rom_idx = quad[0] ? ~raw_idx : raw_idx;
    // Second half of the period is the negative lobe
    assign negate  = quad[1];
endmodule

// File: rtl/carrier_sine_gen.sv
module carrier_sine_gen #(
    parameter int PHASE_W  = 16,
    parameter int IDX_W    = 6,
    parameter int SAMPLE_W = 8,
    parameter int PEAK     = 127
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [PHASE_W-1:0]  freq_inc,
    output logic [SAMPLE_W-1:0] sample,
    output logic                sample_valid
);
    localparam int QUAD_MSB = PHASE_W - 1;
    localparam int IDX_MSB  = PHASE_W - 3;

    typedef struct packed {
        logic [PHASE_W-1:0]  phase;
        logic                pend;
        logic [SAMPLE_W-1:0] smp;
        logic                vld;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [1:0]          quad;
    logic [IDX_W-1:0]    raw_idx;
    logic [IDX_W-1:0]    rom_idx;
    logic                negate;
    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] signed_mag;

    assign quad    = st_q.phase[QUAD_MSB -: 2];
    assign raw_idx = st_q.phase[IDX_MSB -: IDX_W];

    quadrant_fold #(.IDX_W(IDX_W)) u_fold (
        .quad    (quad),
        .raw_idx (raw_idx),
        .rom_idx (rom_idx),
        .negate  (negate)
    );

    quarter_rom #(.IDX_W(IDX_W), .MAG_W(SAMPLE_W), .PEAK(PEAK)) u_rom (
        .idx (rom_idx),
        .mag (mag)
    );

    assign signed_mag = negate ? (~mag + SAMPLE_W'(1)) : mag;

    always_comb begin
        st_d     = st_q;
        st_d.vld = st_q.pend;
        if (st_q.pend) begin
            st_d.smp = signed_mag;
        end
        st_d.pend = step;
        if (step) begin
            st_d.phase = st_q.phase + freq_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample       = st_q.smp;
    assign sample_valid = st_q.vld;
endmodule

// File: rtl/carrier_sine_gen_chk.sv
module carrier_sine_gen_chk #(
    parameter int PHASE_W  = 16,
    parameter int SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step,
    input logic [SAMPLE_W-1:0] sample,
    input logic                sample_valid,
    input logic [PHASE_W-1:0]  phase_q
);
    a_r3_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ##2 sample_valid);

    a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> ##2 !sample_valid);

    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample));

    a_r10_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample != {1'b1, {(SAMPLE_W-1){1'b0}}}));

    // R6/R7 versus R4/R5: sign bit follows the half of the period
    a_r6_sign_follows_half: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample[SAMPLE_W-1] == $past(phase_q[PHASE_W-1])));

    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(phase_q));
endmodule

bind carrier_sine_gen carrier_sine_gen_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step         (step),
    .sample       (sample),
    .sample_valid (sample_valid),
    .phase_q      (st_q.phase)
);

// File: tb/sim_carrier_sine_gen.sv
`timescale 1ns/1ps
module sim_carrier_sine_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic [15:0] freq_inc = '0;
    logic [7:0]  sample;
    logic        sample_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit run_cmp = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    carrier_sine_gen u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .freq_inc(freq_inc),
        .sample(sample), .sample_valid(sample_valid)
    );

    function automatic int mag_ref(input int i);
        return $rtoi(127.0 * $sin((2.0 * i + 1.0) * 3.14159265358979 / 256.0) + 0.5);
    endfunction

    function automatic int wave_ref(input int ph);
        int q, i, m;
        q = (ph >> 14) & 3;
        i = (ph >> 8) & 63;
        if (q[0]) i = 63 - i;
        m = mag_ref(i);
        return q[1] ? -m : m;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_ph = 0, m_sph = 0, m_sample = 0;
    bit m_pend = 0, m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_sph = 0; m_sample = 0; m_pend = 0; m_valid = 0;
        end else begin
            if (m_pend) begin
                m_sample = wave_ref(m_ph);
                m_sph    = m_ph;
            end
            m_valid = m_pend;
            m_pend  = step;
            if (step) m_ph = (m_ph + int'(freq_inc)) & 16'hFFFF;
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk(sample_valid === m_valid, "R3", int'(sample_valid), int'(m_valid));
            if (m_valid) begin
                case ((m_sph >> 14) & 3)
                    0: chk($signed(sample) == m_sample, "R4", $signed(sample), m_sample);
                    1: chk($signed(sample) == m_sample, "R5", $signed(sample), m_sample);
                    2: chk($signed(sample) == m_sample, "R6", $signed(sample), m_sample);
                    default: chk($signed(sample) == m_sample, "R7", $signed(sample), m_sample);
                endcase
                chk($signed(sample) != -128 && sample != 8'd0, "R10", $signed(sample), m_sample);
            end else begin
                chk($signed(sample) == m_sample, "R9", $signed(sample), m_sample);
            end
        end
    end

    // One step, then wait until its sample is visible, then check a literal value
    task automatic single(input logic [15:0] inc, input int expv, input string req);
        @(negedge clk); step = 1'b1; freq_inc = inc;
        @(negedge clk); step = 1'b0; freq_inc = 16'h8000;
        @(negedge clk);
        chk(sample_valid === 1'b1, req, int'(sample_valid), 1);
        chk($signed(sample) == expv, req, $signed(sample), expv);
        @(negedge clk);
        chk(sample_valid === 1'b0, "R3", int'(sample_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sample === 8'd0 && sample_valid === 1'b0, "R1", int'(sample), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sample === 8'd0 && sample_valid === 1'b0, "R1", int'(sample), 0);
        run_cmp = 1'b1;

        single(16'h3F00,  127, "R8");  // phase 0x3F00: q0, peak
        single(16'h4100,   -2, "R6");  // phase 0x8000: q2 i0, smallest entry
        single(16'h3F00, -127, "R6");  // phase 0xBF00
        single(16'h0100, -127, "R7");  // phase 0xC000: mirrored to 63
        single(16'h3F00,   -2, "R7");  // phase 0xFF00: mirrored to 0
        single(16'h0100,    2, "R2");  // wraps to 0x0000, R8 smallest
        single(16'h4000,  127, "R5");  // phase 0x4000: q1 mirrored to 63
        repeat (4) @(negedge clk);     // idle: freq_inc ignored (R2)
        single(16'h3F00,    2, "R5");  // phase 0x7F00: mirrored to 0

        // Unit sweep over one full period: every entry in every quadrant
        for (int k = 0; k < 256; k++) begin
            @(negedge clk); step = 1'b1; freq_inc = 16'h0100;
        end
        // Irregular steps, gaps and increments
        for (int k = 0; k < 800; k++) begin
            @(negedge clk);
            step = ((k % 7) != 4) && ((k % 11) != 2);
            freq_inc = 16'(k * 37 + 16'h0123);
        end
        // Large increment that wraps every step
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); step = 1'b1; freq_inc = 16'hFB55;
        end
        @(negedge clk); step = 1'b0;
        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule